// File: doc/BRIEF.md
# Debug Session State Sequencer

This block keeps track of where an on-chip debug session stands and reports it through a 3-bit state code. Software arms a session, which starts the sequencer in its first state. While armed, match events from comparators elsewhere move it through a fixed chain of states. The chain runs first, second, third and then final. Each stage listens to its own match line.

A session can end in two ways, and they leave different status behind. When software clears the arm bit, the last state code stays visible so that it can be inspected afterwards. When the session ends internally, through an end-of-session input or by reaching the final state, the code returns to zero. Reaching the final state holds the final code for exactly one cycle and raises a final-state pulse.

The block also holds a small trace control register. Its trace-enable bit is write-protected while the part is secured or a session is armed. Its trace-mode and trigger-alignment fields are write-protected only while armed.

Top module: `dbg_seq_top`

## Requirements
- R1: After reset the state code is 000, `armed` is 0, `finalHit` is 0, and the trace-enable, trace-mode and trigger-align outputs are all 0.
- R2: An `armReq` pulse while disarmed makes the next cycle show state code 001 with `armed` at 1.
- R3: While armed, the sequencer advances on the stage's own match line. Code 001 moves to 010 on `matchIn[0]`, 010 moves to 100 on `matchIn[1]`, and 100 moves to 011 (final) on `matchIn[2]`. Match lines that belong to another stage have no effect.
- R4: The final code 011 lasts exactly one cycle, with `finalHit` at 1 during that cycle. The following cycle shows code 000 with `armed` at 0, unless a disarm request arrives during the final cycle.
- R5: A `disarmReq` while armed clears `armed` on the next cycle and leaves the state code unchanged. This also applies when the request arrives during the final cycle, where the code stays 011 and `finalHit` drops.
- R6: An `intEnd` while armed, with no disarm request in the same cycle, makes the next cycle show code 000 with `armed` at 0.
- R7: While disarmed, `matchIn`, `intEnd` and `disarmReq` have no effect, and the state code holds its value.
- R8: An `armReq` while already armed is ignored and does not restart the sequence.
- R9: A register write (`ctlWrEn`) loads `traceEnable` from `ctlWrTrace` only when `secure` is 0 and the block is disarmed. Otherwise `traceEnable` keeps its value.
- R10: A register write loads `traceMode` and `trigAlign` whenever the block is disarmed, regardless of `secure`. While armed, both fields keep their value.
- R11: The state code is only ever 000, 001, 010, 100 or 011. The reserved codes 101, 110 and 111 are never produced.
- R12: Within one cycle, a disarm request wins over an internal end, and an internal end wins over a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| armReq | input | 1 | Software sets the arm bit |
| disarmReq | input | 1 | Software clears the arm bit |
| intEnd | input | 1 | Internal end-of-session event |
| matchIn | input | 3 | Per-stage match events, bit g advances stage g |
| secure | input | 1 | Device is secured |
| ctlWrEn | input | 1 | Write strobe for the trace control register |
| ctlWrTrace | input | 1 | Write data for trace enable |
| ctlWrMode | input | MODE_W | Write data for trace mode |
| ctlWrAlign | input | 1 | Write data for trigger alignment |
| stateFlags | output | 3 | Current state code |
| armed | output | 1 | Session is armed |
| finalHit | output | 1 | Final state reached (one-cycle pulse) |
| traceEnable | output | 1 | Trace-enable control bit |
| traceMode | output | MODE_W | Trace mode field |
| trigAlign | output | 1 | Trigger alignment bit |

## Verification
Every result is registered. An input that is driven between edges is taken at the next rising edge, and its effect shows on the outputs straight after that edge, one cycle later. The only exception is `finalHit`, which decodes the registered state and so appears in the same cycle that code 011 appears. The bench changes inputs on falling edges and samples outputs on the following falling edge. This means each check looks exactly one edge after its stimulus, and multi-step sequences such as the final pulse are checked cycle by cycle.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

  localparam int unsigned CODE_W     = 3;
  localparam int unsigned NUM_STAGES = 3;

  typedef enum logic [CODE_W-1:0] {
    SEQ_IDLE  = 3'b000,
    SEQ_S1    = 3'b001,
    SEQ_S2    = 3'b010,
    SEQ_S3    = 3'b100,
    SEQ_FINAL = 3'b011
  } seqCode_e;

  // Strobes from control to datapath, at most one session strobe per cycle.
  typedef struct packed {
    logic doArm;
    logic doDisarm;
    logic doEnd;
    logic doAdvance;
    logic wrTraceEn;
    logic wrModeAlign;
  } seqStrobe_t;

  // Stage g listens to match line g.
  function automatic seqCode_e stageCode(int unsigned g);
    case (g)
      0:       stageCode = SEQ_S1;
      1:       stageCode = SEQ_S2;
      default: stageCode = SEQ_S3;
    endcase
  endfunction

  function automatic seqCode_e advanceCode(seqCode_e cur);
    case (cur)
      SEQ_S1:  advanceCode = SEQ_S2;
      SEQ_S2:  advanceCode = SEQ_S3;
      SEQ_S3:  advanceCode = SEQ_FINAL;
      default: advanceCode = cur;
    endcase
  endfunction

endpackage

// File: rtl/dbgseq_ctrl.sv
module dbgseq_ctrl
  import dbgseq_pkg::*;
(
  input  logic                  armReq,
  input  logic                  disarmReq,
  input  logic                  intEnd,
  input  logic [NUM_STAGES-1:0] matchIn,
  input  logic                  secure,
  input  logic                  ctlWrEn,
  input  seqCode_e              curState,
  input  logic                  curArmed,
  output seqStrobe_t            strobe
);

  logic [NUM_STAGES-1:0] stageHit;
  logic                  anyHit;
  logic                  atFinal;

  // One hit per stage: its own match line while sitting in that stage.
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    assign stageHit[g] = matchIn[g] && (curState == stageCode(g));
  end

  assign anyHit  = |stageHit;
  assign atFinal = (curState == SEQ_FINAL);

  // Priority: disarm, then internal end (input or final state), then match.
  always_comb begin
    strobe             = '0;
    strobe.doDisarm    = curArmed && disarmReq;
    strobe.doEnd       = curArmed && !disarmReq && (intEnd || atFinal);
    strobe.doAdvance   = curArmed && !disarmReq && !intEnd && !atFinal && anyHit;
    strobe.doArm       = !curArmed && armReq;
    strobe.wrTraceEn   = ctlWrEn && !curArmed && !secure;
    strobe.wrModeAlign = ctlWrEn && !curArmed;
  end

endmodule

// File: rtl/dbgseq_dpath.sv
module dbgseq_dpath
  import dbgseq_pkg::*;
#(
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              ctlWrTrace,
  input  logic [MODE_W-1:0] ctlWrMode,
  input  logic              ctlWrAlign,
  output seqCode_e          curState,
  output logic              curArmed,
  output logic              traceEnQ,
  output logic [MODE_W-1:0] traceModeQ,
  output logic              trigAlignQ
);

  seqCode_e stateQ;
  logic     armedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= SEQ_IDLE;
      armedQ <= 1'b0;
    end else if (strobe.doDisarm) begin
      armedQ <= 1'b0;
    end else if (strobe.doEnd) begin
      stateQ <= SEQ_IDLE;
      armedQ <= 1'b0;
    end else if (strobe.doArm) begin
      stateQ <= SEQ_S1;
      armedQ <= 1'b1;
    end else if (strobe.doAdvance) begin
      stateQ <= advanceCode(stateQ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      traceEnQ   <= 1'b0;
      traceModeQ <= '0;
      trigAlignQ <= 1'b0;
    end else begin
      if (strobe.wrTraceEn) traceEnQ <= ctlWrTrace;
      if (strobe.wrModeAlign) begin
        traceModeQ <= ctlWrMode;
        trigAlignQ <= ctlWrAlign;
      end
    end
  end

  assign curState = stateQ;
  assign curArmed = armedQ;

endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
  import dbgseq_pkg::*;
#(
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armReq,
  input  logic              disarmReq,
  input  logic              intEnd,
  input  logic [2:0]        matchIn,
  input  logic              secure,
  input  logic              ctlWrEn,
  input  logic              ctlWrTrace,
  input  logic [MODE_W-1:0] ctlWrMode,
  input  logic              ctlWrAlign,
  output logic [2:0]        stateFlags,
  output logic              armed,
  output logic              finalHit,
  output logic              traceEnable,
  output logic [MODE_W-1:0] traceMode,
  output logic              trigAlign
);

  seqStrobe_t strobe;
  seqCode_e   curState;
  logic       curArmed;

  dbgseq_ctrl ctrl_i (
    .armReq    (armReq),
    .disarmReq (disarmReq),
    .intEnd    (intEnd),
    .matchIn   (matchIn),
    .secure    (secure),
    .ctlWrEn   (ctlWrEn),
    .curState  (curState),
    .curArmed  (curArmed),
    .strobe    (strobe)
  );

  dbgseq_dpath #(.MODE_W(MODE_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .ctlWrTrace (ctlWrTrace),
    .ctlWrMode  (ctlWrMode),
    .ctlWrAlign (ctlWrAlign),
    .curState   (curState),
    .curArmed   (curArmed),
    .traceEnQ   (traceEnable),
    .traceModeQ (traceMode),
    .trigAlignQ (trigAlign)
  );

  assign stateFlags = curState;
  assign armed      = curArmed;
  assign finalHit   = curArmed && (curState == SEQ_FINAL);

endmodule

// File: rtl/dbgseq_chk.sv
module dbgseq_chk #(
  parameter int unsigned MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              armReq,
  input logic              disarmReq,
  input logic              intEnd,
  input logic [2:0]        matchIn,
  input logic              secure,
  input logic              ctlWrEn,
  input logic [2:0]        stateFlags,
  input logic              armed,
  input logic              finalHit,
  input logic              traceEnable,
  input logic [MODE_W-1:0] traceMode,
  input logic              trigAlign
);

  p_arm_enter_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && armReq) |=> (armed && stateFlags == 3'b001));

  p_final_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    finalHit |=> !finalHit);

  p_final_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (finalHit && !disarmReq) |=> (!armed && stateFlags == 3'b000));

  p_disarm_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && disarmReq) |=> (!armed && $stable(stateFlags)));

  p_int_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !disarmReq && intEnd) |=> (!armed && stateFlags == 3'b000));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !armReq) |=> (!armed && $stable(stateFlags)));

  p_trace_lock_r9: assert property (@(posedge clk) disable iff (!rstN)
    (secure || armed || !ctlWrEn) |=> $stable(traceEnable));

  p_mode_lock_r10: assert property (@(posedge clk) disable iff (!rstN)
    (armed || !ctlWrEn) |=> ($stable(traceMode) && $stable(trigAlign)));

  p_no_reserved_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stateFlags != 3'b101 && stateFlags != 3'b110 && stateFlags != 3'b111));

  p_final_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    finalHit |-> (armed && stateFlags == 3'b011));

  // Unused in properties but kept so the bind lists every port.
  logic unusedSig;
  assign unusedSig = ^matchIn;

endmodule

bind dbg_seq_top dbgseq_chk #(.MODE_W(MODE_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .armReq      (armReq),
  .disarmReq   (disarmReq),
  .intEnd      (intEnd),
  .matchIn     (matchIn),
  .secure      (secure),
  .ctlWrEn     (ctlWrEn),
  .stateFlags  (stateFlags),
  .armed       (armed),
  .finalHit    (finalHit),
  .traceEnable (traceEnable),
  .traceMode   (traceMode),
  .trigAlign   (trigAlign)
);

// File: tb/dbg_seq_top_tb_top.sv
`timescale 1ns/100ps
module dbg_seq_top_tb_top;

  localparam int unsigned MODE_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              armReq = 1'b0;
  logic              disarmReq = 1'b0;
  logic              intEnd = 1'b0;
  logic [2:0]        matchIn = '0;
  logic              secure = 1'b0;
  logic              ctlWrEn = 1'b0;
  logic              ctlWrTrace = 1'b0;
  logic [MODE_W-1:0] ctlWrMode = '0;
  logic              ctlWrAlign = 1'b0;
  logic [2:0]        stateFlags;
  logic              armed;
  logic              finalHit;
  logic              traceEnable;
  logic [MODE_W-1:0] traceMode;
  logic              trigAlign;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit rsvSeen = 0;

  always #2.5 clk = ~clk;

  dbg_seq_top #(.MODE_W(MODE_W)) dut_i (
    .clk(clk), .rstN(rstN), .armReq(armReq), .disarmReq(disarmReq),
    .intEnd(intEnd), .matchIn(matchIn), .secure(secure), .ctlWrEn(ctlWrEn),
    .ctlWrTrace(ctlWrTrace), .ctlWrMode(ctlWrMode), .ctlWrAlign(ctlWrAlign),
    .stateFlags(stateFlags), .armed(armed), .finalHit(finalHit),
    .traceEnable(traceEnable), .traceMode(traceMode), .trigAlign(trigAlign)
  );

  // R11 monitor: record any reserved code seen on a falling edge.
  always @(negedge clk) begin
    if (rstN && (stateFlags == 3'b101 || stateFlags == 3'b110 || stateFlags == 3'b111))
      rsvSeen = 1;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One edge: inputs change on the falling edge, results read one falling edge later.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearIn();
    armReq = 0; disarmReq = 0; intEnd = 0; matchIn = '0; ctlWrEn = 0;
  endtask

  task automatic pulse_arm();
    armReq = 1; tick(); clearIn();
  endtask

  task automatic pulse_match(input int idx);
    matchIn = 3'b001 << idx; tick(); clearIn();
  endtask

  task automatic t_reset();
    check("R1 state", stateFlags, 0);
    check("R1 armed", armed, 0);
    check("R1 final", finalHit, 0);
    check("R1 trace", {traceEnable, traceMode, trigAlign}, 0);
  endtask

  task automatic t_walk();
    pulse_arm();
    check("R2 state after arm", stateFlags, 1);
    check("R2 armed", armed, 1);
    matchIn = 3'b110; tick(); clearIn();
    check("R3 foreign match in state1", stateFlags, 1);
    pulse_match(0);
    check("R3 state2", stateFlags, 2);
    pulse_match(2);
    check("R3 foreign match in state2", stateFlags, 2);
    pulse_match(1);
    check("R3 state3", stateFlags, 4);
    pulse_match(2);
    check("R3 final code", stateFlags, 3);
    check("R4 final pulse", finalHit, 1);
    tick();
    check("R4 back to idle", stateFlags, 0);
    check("R4 disarmed", armed, 0);
    check("R4 pulse drops", finalHit, 0);
  endtask

  task automatic t_sw_disarm();
    pulse_arm();
    pulse_match(0);
    disarmReq = 1; tick(); clearIn();
    check("R5 code kept", stateFlags, 2);
    check("R5 disarmed", armed, 0);
  endtask

  task automatic t_idle_ignore();
    matchIn = 3'b111; intEnd = 1; disarmReq = 1; tick(); clearIn();
    check("R7 code held", stateFlags, 2);
    check("R7 stays disarmed", armed, 0);
  endtask

  task automatic t_int_end();
    pulse_arm();
    pulse_match(0);
    pulse_match(1);
    intEnd = 1; matchIn = 3'b100; tick(); clearIn();
    check("R6 R12 end beats match", stateFlags, 0);
    check("R6 disarmed", armed, 0);
  endtask

  task automatic t_rearm();
    pulse_arm();
    pulse_match(0);
    pulse_arm();
    check("R8 rearm ignored", stateFlags, 2);
    check("R8 still armed", armed, 1);
    disarmReq = 1; intEnd = 1; tick(); clearIn();
    check("R12 disarm beats end", stateFlags, 2);
  endtask

  task automatic t_disarm_final();
    pulse_arm();
    pulse_match(0);
    pulse_match(1);
    pulse_match(2);
    disarmReq = 1; tick(); clearIn();
    check("R5 final kept", stateFlags, 3);
    check("R5 final pulse off", finalHit, 0);
    tick();
    check("R7 final held idle", stateFlags, 3);
    pulse_arm();
    check("R2 rearm from final", stateFlags, 1);
    disarmReq = 1; tick(); clearIn();
  endtask

  task automatic t_trace_regs();
    ctlWrEn = 1; ctlWrTrace = 1; ctlWrMode = 2'b10; ctlWrAlign = 1; tick(); clearIn();
    check("R9 write when open", traceEnable, 1);
    check("R10 mode when open", traceMode, 2);
    secure = 1;
    ctlWrEn = 1; ctlWrTrace = 0; ctlWrMode = 2'b01; ctlWrAlign = 0; tick(); clearIn();
    check("R9 secured blocks", traceEnable, 1);
    check("R10 secured allows mode", traceMode, 1);
    check("R10 secured allows align", trigAlign, 0);
    secure = 0;
    pulse_arm();
    ctlWrEn = 1; ctlWrTrace = 0; ctlWrMode = 2'b11; ctlWrAlign = 1; tick(); clearIn();
    check("R9 armed blocks", traceEnable, 1);
    check("R10 armed blocks mode", traceMode, 1);
    check("R10 armed blocks align", trigAlign, 0);
    disarmReq = 1; tick(); clearIn();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    tick();
    t_reset();
    t_walk();
    t_sw_disarm();
    t_idle_ignore();
    t_int_end();
    t_rearm();
    t_disarm_final();
    t_trace_regs();
    check("R11 no reserved code", int'(rsvSeen), 0);
    finish_run();
  end

endmodule